// File: doc/BRIEF.md
# Gigabit Receive Status Classifier

This block watches the receive side of a byte-wide gigabit media-independent interface. Each receive clock it samples the data-valid strobe, the control/error strobe and the 8-bit receive byte. It sorts the cycle into exactly one of six classes: inter-frame, data, errored data, carrier extension, false carrier or reserved. The class is presented one cycle later as a registered one-hot flag set.

Beside the per-cycle class, the block tracks frame boundaries. It emits single-cycle start and end pulses and a sticky frame-error flag that holds until the next frame begins. It also drives a carrier-sense output and raises a protocol-violation pulse when a carrier-extension cycle appears without a frame or an earlier extension cycle directly before it. A receive MAC uses these outputs to qualify frames without decoding the raw strobes itself.

Top module: `gmii_rx_classifier`

## Requirements
- R1: With rx_dv=1 and rx_ctrl=0 the cycle is classed as data (cls_data).
- R2: With rx_dv=1 and rx_ctrl=1 the cycle is classed as errored data (cls_data_err), whatever rxd holds.
- R3: With rx_dv=0 and rx_ctrl=0 the cycle is inter-frame (cls_idle) for every rxd value.
- R4: With rx_dv=0 and rx_ctrl=1, a low nibble rxd[3:0]=0h gives inter-frame, checked first, so 50h is inter-frame.
- R5: With rx_dv=0 and rx_ctrl=1, a low nibble of Eh gives false carrier (cls_false_carrier); this is checked before the extension rule, so 5Eh is false carrier.
- R6: With rx_dv=0 and rx_ctrl=1, a high nibble rxd[7:4]=5h with a low nibble other than 0h and Eh gives carrier extension (cls_ext).
- R7: With rx_dv=0 and rx_ctrl=1, any other byte is reserved (cls_reserved).
- R8: The six class flags are registered, valid one clock after the inputs are sampled, and exactly one is high at any time.
- R9: frame_start pulses for one cycle for a cycle with rx_dv=1 whose previous cycle had rx_dv=0.
- R10: frame_end pulses for one cycle for a cycle with rx_dv=0 whose previous cycle had rx_dv=1.
- R11: frame_err goes high with the first errored-data cycle of a frame and stays high until the next frame start. At that start it takes the error state of the start cycle itself.
- R12: carrier_sense is high for data, errored data, extension and false-carrier cycles, and low for inter-frame and reserved cycles.
- R13: ext_violation pulses with a carrier-extension cycle whose previous cycle was neither rx_dv=1 nor an extension cycle.
- R14: While rst_n is low, cls_idle is 1 and every other output is 0. The history counts as inter-frame after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_dv | input | 1 | Receive data-valid strobe |
| rx_ctrl | input | 1 | Receive control/error strobe |
| rxd | input | 8 | Receive byte |
| cls_idle | output | 1 | Cycle was inter-frame |
| cls_data | output | 1 | Cycle was data |
| cls_data_err | output | 1 | Cycle was errored data |
| cls_ext | output | 1 | Cycle was carrier extension |
| cls_false_carrier | output | 1 | Cycle was false carrier |
| cls_reserved | output | 1 | Cycle used a reserved code |
| frame_start | output | 1 | First data cycle of a frame |
| frame_end | output | 1 | First non-data cycle after a frame |
| frame_err | output | 1 | Sticky error flag of the current or last frame |
| carrier_sense | output | 1 | Carrier present on this cycle |
| ext_violation | output | 1 | Extension cycle without a frame or extension before it |

## Verification
The bench goes after the overlapping codes 50h, 5Eh, 5Fh and 0Eh. A design with the priority checks in the wrong order would report 50h as extension or 5Eh as extension instead of false carrier. It also drives an error on the very first frame cycle and follows it with a clean frame. A frame-error flag that clears a cycle late, or misses an error on the start cycle, shows up there. Extension cycles are placed straight after idle, after a frame and in long runs, which exposes a violation check that looks at the wrong history. Random mixes of strobes and bytes, biased toward the interesting nibbles, cover the remaining combinations.

// File: rtl/gmii_rx_pkg.sv
package gmii_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;

  localparam logic [NIB_W-1:0] NIB_IDLE  = 4'h0;
  localparam logic [NIB_W-1:0] NIB_FALSE = 4'hE;
  localparam logic [NIB_W-1:0] NIB_EXT   = 4'h5;

  localparam int NUM_CLS = 6;

  typedef enum logic [2:0] {
    CLS_IDLE  = 3'd0,
    CLS_DATA  = 3'd1,
    CLS_DERR  = 3'd2,
    CLS_EXT   = 3'd3,
    CLS_FALSE = 3'd4,
    CLS_RSVD  = 3'd5
  } rx_cls_e;
endpackage

// File: rtl/gmii_rx_decode.sv
module gmii_rx_decode
  import gmii_rx_pkg::*;
(
  input  logic              rx_dv,
  input  logic              rx_ctrl,
  input  logic [BYTE_W-1:0] rxd,
  output rx_cls_e           cls
);
  logic [NIB_W-1:0] lo_nib;
  logic [NIB_W-1:0] hi_nib;

  assign lo_nib = rxd[NIB_W-1:0];
  assign hi_nib = rxd[BYTE_W-1:NIB_W];

  // Priority: strobes first, then low nibble idle, low nibble false, high nibble ext.
  always_comb begin
    if (rx_dv) begin
      cls = rx_ctrl ? CLS_DERR : CLS_DATA;
    end else if (!rx_ctrl) begin
      cls = CLS_IDLE;
    end else if (lo_nib == NIB_IDLE) begin
      cls = CLS_IDLE;
    end else if (lo_nib == NIB_FALSE) begin
      cls = CLS_FALSE;
    end else if (hi_nib == NIB_EXT) begin
      cls = CLS_EXT;
    end else begin
      cls = CLS_RSVD;
    end
  end
endmodule

// File: rtl/gmii_rx_tracker.sv
module gmii_rx_tracker
  import gmii_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rx_dv,
  input  rx_cls_e cls,
  output logic    frame_start,
  output logic    frame_end,
  output logic    frame_err,
  output logic    carrier_sense,
  output logic    ext_violation
);
  logic prev_dv_q,  prev_dv_d;
  logic prev_ext_q, prev_ext_d;
  logic start_q,    start_d;
  logic end_q,      end_d;
  logic err_q,      err_d;
  logic crs_q,      crs_d;
  logic viol_q,     viol_d;
  logic is_derr, is_ext;
  logic upd_en;

  assign upd_en  = 1'b1;
  assign is_derr = (cls == CLS_DERR);
  assign is_ext  = (cls == CLS_EXT);

  always_comb begin
    prev_dv_d  = rx_dv;
    prev_ext_d = is_ext;
    start_d    = rx_dv && !prev_dv_q;
    end_d      = !rx_dv && prev_dv_q;
    err_d      = start_d ? is_derr : (err_q || is_derr);
    crs_d      = (cls == CLS_DATA) || is_derr || is_ext || (cls == CLS_FALSE);
    viol_d     = is_ext && !(prev_dv_q || prev_ext_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_dv_q  <= 1'b0;
      prev_ext_q <= 1'b0;
      start_q    <= 1'b0;
      end_q      <= 1'b0;
      err_q      <= 1'b0;
      crs_q      <= 1'b0;
      viol_q     <= 1'b0;
    end else if (upd_en) begin
      prev_dv_q  <= prev_dv_d;
      prev_ext_q <= prev_ext_d;
      start_q    <= start_d;
      end_q      <= end_d;
      err_q      <= err_d;
      crs_q      <= crs_d;
      viol_q     <= viol_d;
    end
  end

  assign frame_start   = start_q;
  assign frame_end     = end_q;
  assign frame_err     = err_q;
  assign carrier_sense = crs_q;
  assign ext_violation = viol_q;

  // R9: a start pulse cannot repeat on the next cycle
  p_start_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  // R10: start and end never coincide
  p_start_end_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start && frame_end));
  // R11: the sticky flag only drops at a frame start
  p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_err) |-> frame_start);
  // R13: a violation implies carrier present
  p_viol_crs_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ext_violation |-> carrier_sense);
endmodule

// File: rtl/gmii_rx_classifier.sv
module gmii_rx_classifier
  import gmii_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_dv,
  input  logic       rx_ctrl,
  input  logic [7:0] rxd,
  output logic       cls_idle,
  output logic       cls_data,
  output logic       cls_data_err,
  output logic       cls_ext,
  output logic       cls_false_carrier,
  output logic       cls_reserved,
  output logic       frame_start,
  output logic       frame_end,
  output logic       frame_err,
  output logic       carrier_sense,
  output logic       ext_violation
);
  rx_cls_e              cls_now;
  logic [NUM_CLS-1:0]   cls_oh_d, cls_oh_q;
  logic                 cls_en;

  gmii_rx_decode u_decode (
    .rx_dv   (rx_dv),
    .rx_ctrl (rx_ctrl),
    .rxd     (rxd),
    .cls     (cls_now)
  );

  gmii_rx_tracker u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_dv         (rx_dv),
    .cls           (cls_now),
    .frame_start   (frame_start),
    .frame_end     (frame_end),
    .frame_err     (frame_err),
    .carrier_sense (carrier_sense),
    .ext_violation (ext_violation)
  );

  assign cls_en = 1'b1;

  always_comb begin
    cls_oh_d = '0;
    cls_oh_d[cls_now] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_oh_q <= NUM_CLS'(1) << CLS_IDLE;
    end else if (cls_en) begin
      cls_oh_q <= cls_oh_d;
    end
  end

  assign cls_idle          = cls_oh_q[CLS_IDLE];
  assign cls_data          = cls_oh_q[CLS_DATA];
  assign cls_data_err      = cls_oh_q[CLS_DERR];
  assign cls_ext           = cls_oh_q[CLS_EXT];
  assign cls_false_carrier = cls_oh_q[CLS_FALSE];
  assign cls_reserved      = cls_oh_q[CLS_RSVD];

  // R8: exactly one class flag
  p_one_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cls_oh_q) == 1);
  // R12: no carrier on inter-frame or reserved cycles
  p_crs_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_idle || cls_reserved) |-> !carrier_sense);
  // R13: a violation only accompanies an extension cycle
  p_viol_ext_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ext_violation |-> cls_ext);
  // R9: a frame start accompanies a data-class cycle
  p_start_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (cls_data || cls_data_err));
  // R10: a frame end accompanies a non-data cycle
  p_end_nodata_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> !(cls_data || cls_data_err));
endmodule

// File: tb/gmii_rx_classifier_tb.sv
`timescale 1ns/1ps
module gmii_rx_classifier_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic rx_dv, rx_ctrl;
  logic [7:0] rxd;
  logic cls_idle, cls_data, cls_data_err, cls_ext, cls_false_carrier, cls_reserved;
  logic frame_start, frame_end, frame_err, carrier_sense, ext_violation;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model history
  bit m_prev_dv, m_prev_ext, m_err;

  always #2.5 clk = ~clk;

  gmii_rx_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_ctrl(rx_ctrl), .rxd(rxd),
    .cls_idle(cls_idle), .cls_data(cls_data), .cls_data_err(cls_data_err),
    .cls_ext(cls_ext), .cls_false_carrier(cls_false_carrier),
    .cls_reserved(cls_reserved), .frame_start(frame_start),
    .frame_end(frame_end), .frame_err(frame_err),
    .carrier_sense(carrier_sense), .ext_violation(ext_violation)
  );

  // class codes: 0 idle,1 data,2 derr,3 ext,4 false,5 reserved
  function automatic int exp_class(bit dv, bit ctrl, logic [7:0] b);
    if (dv) return ctrl ? 2 : 1;
    if (!ctrl) return 0;
    if (b[3:0] == 4'h0) return 0;
    if (b[3:0] == 4'hE) return 4;
    if (b[7:4] == 4'h5) return 3;
    return 5;
  endfunction

  function automatic string cls_tag(int c, bit ctrl);
    case (c)
      1: return "R1";
      2: return "R2";
      0: return ctrl ? "R4" : "R3";
      4: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] cls_vec();
    return {2'b00, cls_reserved, cls_false_carrier, cls_ext, cls_data_err, cls_data, cls_idle};
  endfunction

  // drive one cycle (called just after a negedge), check at the following negedge
  task automatic step(bit dv, bit ctrl, logic [7:0] b);
    int c;
    bit e_start, e_end, e_crs, e_viol;
    rx_dv = dv; rx_ctrl = ctrl; rxd = b;
    c = exp_class(dv, ctrl, b);
    e_start = dv && !m_prev_dv;
    e_end   = !dv && m_prev_dv;
    if (e_start) m_err = (c == 2);
    else if (c == 2) m_err = 1;
    e_crs  = (c >= 1 && c <= 4);
    e_viol = (c == 3) && !(m_prev_dv || m_prev_ext);
    m_prev_dv  = dv;
    m_prev_ext = (c == 3);
    @(negedge clk);
    chk(cls_tag(c, ctrl), cls_vec(), 8'(1 << c));
    chk("R9",  {7'd0, frame_start},   {7'd0, e_start});
    chk("R10", {7'd0, frame_end},     {7'd0, e_end});
    chk("R11", {7'd0, frame_err},     {7'd0, m_err});
    chk("R12", {7'd0, carrier_sense}, {7'd0, e_crs});
    chk("R13", {7'd0, ext_violation}, {7'd0, e_viol});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 20240611;
    void'($urandom(seed));
    rst_n = 1'b0; rx_dv = 0; rx_ctrl = 0; rxd = 8'h00;
    m_prev_dv = 0; m_prev_ext = 0; m_err = 0;
    repeat (3) @(negedge clk);
    // R14: reset values
    chk("R14", cls_vec(), 8'h01);
    chk("R14", {3'd0, frame_start, frame_end, frame_err, carrier_sense, ext_violation}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // directed priority corners
    step(0, 0, 8'h5E);  // R3 idle regardless of byte
    step(0, 1, 8'h50);  // R4 50h is idle
    step(0, 1, 8'h5E);  // R5 5Eh false carrier
    step(0, 1, 8'h0E);  // R5
    step(0, 1, 8'h5F);  // R6 extension, no frame before: R13 violation
    step(0, 1, 8'h55);  // R6 run, no violation
    step(0, 1, 8'h3A);  // R7 reserved
    // frame with error on first cycle, then extension
    step(1, 1, 8'h55);  // R2, R9, R11
    step(1, 0, 8'hD5);  // R1
    step(0, 1, 8'h51);  // R10, R6 legal ext
    step(0, 1, 8'h5A);
    step(0, 0, 8'h00);
    // clean frame clears error at start
    step(1, 0, 8'h55);  // R11 clear
    step(1, 0, 8'h12);
    step(1, 1, 8'h34);  // R11 set mid-frame
    step(1, 0, 8'h56);
    step(0, 0, 8'h00);  // R10
    step(0, 0, 8'h00);  // R11 holds

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      bit dv, ctrl;
      logic [7:0] b;
      int sel;
      dv   = ($urandom % 3) == 0;
      ctrl = ($urandom % 2) == 1;
      sel  = $urandom % 4;
      b    = 8'($urandom);
      if (sel == 0) b[7:4] = 4'h5;
      else if (sel == 1) b[3:0] = ($urandom % 2) ? 4'hE : 4'h0;
      step(dv, ctrl, b);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule